// File: doc/BRIEF.md
# Dual-FIFO Inter-Processor Mailbox

This block carries short messages between an application processor and an I/O co-processor. It holds two one-way queues. The outbound queue runs from the application side to the I/O side, and the inbound queue runs back the other way. Every message pairs a 64-bit word with a 32-bit word. Both processors reach the block through one shared register window on a simple single-cycle bus.

To send, a processor writes the 64-bit word to a holding register. It then writes the 32-bit word, and that second write commits the pair to the queue. To receive, a processor may first read the 64-bit word of the oldest entry, which does not remove it. Reading the 32-bit word removes the entry. The 32-bit receive read also returns the queue's pointers and traffic counts in its upper bits.

Each queue feeds two latched interrupt sources, one for "empty" and one for "not empty". A latched source stays set until software acknowledges it. Two of the four sources drive level outputs, each gated by its own enable bit.

Top module: `ipc_mailbox`

## Requirements
- R1: Writing the 64-bit send word and then the 32-bit send word of a queue enqueues that pair. The queue's receive words return the pairs in the order they were sent. A read returns its data on `reg_rdata` in the cycle after the one with `reg_rd_en` high; any other cycle shows zero there. Register offsets: outbound queue control 0x50, send words 0x60 (64-bit) and 0x68 (32-bit), receive words 0x70 (64-bit) and 0x78 (32-bit). Inbound queue control 0x80, send words 0x90/0x98, receive words 0xA0/0xA8.
- R2: A control register reads bit 16 = 1 when its queue is full and bit 17 = 1 when it is empty; all other bits read 0. Both queues are empty after reset.
- R3: Each queue holds 16 entries and reports full after the 16th unread entry.
- R4: A 32-bit send write while the queue is full is dropped. The 16 stored entries come back unchanged and in order.
- R5: Reading the 64-bit receive word does not dequeue, so repeated reads return the same head. Reading either receive word of an empty queue returns zero and changes no pointer.
- R6: The 32-bit receive read returns the message in bits [31:0], the write pointer in [43:40], the read pointer in [47:44], the enqueue count in [51:48] and the dequeue count in [56:52]. All other bits are zero. Pointers wrap modulo 16. The enqueue count saturates at 15 and the dequeue count at 31. The values shown are those before the read's own dequeue.
- R7: Interrupt source bits are: bit 0 outbound empty, bit 1 outbound not empty, bit 2 inbound empty, bit 3 inbound not empty. A source latches whenever its condition holds and stays latched after the condition clears. Reading 0x4C returns the latched bits in [3:0].
- R8: Writing 1 to a bit of 0x4C clears that latched source for one cycle. If its condition still holds, the source is set again on the next clock edge; otherwise it stays clear.
- R9: The enable register at 0x48 (bits [3:0], readable) resets to 0, and latched bits reset to 0. `irq_send_empty` equals latched bit 0 AND enable bit 0. `irq_recv_not_empty` equals latched bit 3 AND enable bit 3.
- R10: Unmapped offsets read zero and ignore writes. Writes to control or receive offsets change nothing.
- R11: The two queues are independent: traffic on one never alters the other's contents, flags or fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rd_en | input | 1 | Read strobe |
| reg_rdata | output | 64 | Read data, one cycle after the strobe |
| irq_send_empty | output | 1 | Outbound-empty interrupt, latched and enabled |
| irq_recv_not_empty | output | 1 | Inbound-not-empty interrupt, latched and enabled |

## Verification
The bench fills a queue to 16 and sends a 17th message. A design that overwrites or advances would corrupt or shift the drained sequence. It reads both receive words of an empty queue; a design that pops anyway moves the read pointer, and the next status word shows it. It checks that the acknowledge-while-true case drops the interrupt for exactly one cycle, and that a source stays latched after its condition has gone. A level-following design fails the latch check, and one that ignores the acknowledge fails the drop. Long random traffic drives the enqueue and dequeue counts into saturation and the pointers through several wraps, so a count that rolls over would show a wrong status word.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

    localparam int ADDR_W     = 8;
    localparam int WORD_W     = 64;
    localparam int LO_W       = 32;
    localparam int MBOX_DEPTH = 16;
    localparam int PTR_W      = $clog2(MBOX_DEPTH);
    localparam int IN_CNT_W   = 4;
    localparam int OUT_CNT_W  = 5;
    localparam int NUM_DIR    = 2;
    localparam int NUM_SRC    = 2 * NUM_DIR;

    // field positions decoded by software
    localparam int FULL_BIT   = 16;
    localparam int EMPTY_BIT  = 17;
    localparam int WPTR_LSB   = 40;
    localparam int RPTR_LSB   = 44;
    localparam int INCNT_LSB  = 48;
    localparam int OUTCNT_LSB = 52;

    localparam logic [ADDR_W-1:0] IRQ_EN_ADDR  = 8'h48;
    localparam logic [ADDR_W-1:0] IRQ_ACK_ADDR = 8'h4C;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [LO_W-1:0]   lo;
    } mbox_msg_t;

    typedef struct packed {
        logic                 full;
        logic                 empty;
        logic [PTR_W-1:0]     wptr;
        logic [PTR_W-1:0]     rptr;
        logic [IN_CNT_W-1:0]  in_cnt;
        logic [OUT_CNT_W-1:0] out_cnt;
    } fifo_stat_t;

    function automatic logic [ADDR_W-1:0] ctl_addr(input int d);
        return (d == 0) ? ADDR_W'(8'h50) : ADDR_W'(8'h80);
    endfunction

    function automatic logic [ADDR_W-1:0] send_hi_addr(input int d);
        return ctl_addr(d) + ADDR_W'(8'h10);
    endfunction

    function automatic logic [ADDR_W-1:0] send_lo_addr(input int d);
        return ctl_addr(d) + ADDR_W'(8'h18);
    endfunction

    function automatic logic [ADDR_W-1:0] recv_hi_addr(input int d);
        return ctl_addr(d) + ADDR_W'(8'h20);
    endfunction

    function automatic logic [ADDR_W-1:0] recv_lo_addr(input int d);
        return ctl_addr(d) + ADDR_W'(8'h28);
    endfunction

    function automatic logic [WORD_W-1:0] pack_recv_lo(input fifo_stat_t s,
                                                       input logic [LO_W-1:0] lo);
        logic [WORD_W-1:0] r;
        r = '0;
        r[LO_W-1:0]                   = lo;
        r[WPTR_LSB +: PTR_W]          = s.wptr;
        r[RPTR_LSB +: PTR_W]          = s.rptr;
        r[INCNT_LSB +: IN_CNT_W]      = s.in_cnt;
        r[OUTCNT_LSB +: OUT_CNT_W]    = s.out_cnt;
        return r;
    endfunction

endpackage

// File: rtl/ipc_mbox_fifo.sv
module ipc_mbox_fifo
    import ipc_mbox_pkg::*;
#(
    parameter int DEPTH = MBOX_DEPTH,
    parameter int IN_W  = IN_CNT_W,
    parameter int OUT_W = OUT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  mbox_msg_t        din,
    input  logic             pop,
    output mbox_msg_t        dout,
    output logic             full,
    output logic             empty,
    output logic [$clog2(DEPTH)-1:0] wptr,
    output logic [$clog2(DEPTH)-1:0] rptr,
    output logic [IN_W-1:0]  in_cnt,
    output logic [OUT_W-1:0] out_cnt
);
    localparam int PW = $clog2(DEPTH);

    mbox_msg_t     mem [DEPTH];
    logic [PW:0]   occ;

    assign full  = (occ == (PW+1)'(DEPTH));
    assign empty = (occ == '0);
    assign dout  = mem[rptr];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            rptr    <= '0;
            occ     <= '0;
            in_cnt  <= '0;
            out_cnt <= '0;
        end else begin
            if (push) begin
                wptr <= wptr + PW'(1);
                if (in_cnt != '1) in_cnt <= in_cnt + IN_W'(1);
            end
            if (pop) begin
                rptr <= rptr + PW'(1);
                if (out_cnt != '1) out_cnt <= out_cnt + OUT_W'(1);
            end
            case ({push, pop})
                2'b10:   occ <= occ + (PW+1)'(1);
                2'b01:   occ <= occ - (PW+1)'(1);
                default: occ <= occ;
            endcase
        end
    end
endmodule

// File: rtl/ipc_mbox_chan.sv
module ipc_mbox_chan
    import ipc_mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pop_req,
    output mbox_msg_t         head,
    output fifo_stat_t        stat
);
    logic [WORD_W-1:0] stage_q;
    logic              push;
    logic              pop;
    mbox_msg_t         entry;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (wr_hi) begin
            stage_q <= wdata;
        end
    end

    assign push     = wr_lo && !stat.full;
    assign pop      = pop_req && !stat.empty;
    assign entry.hi = stage_q;
    assign entry.lo = wdata[LO_W-1:0];

    ipc_mbox_fifo #(
        .DEPTH (MBOX_DEPTH),
        .IN_W  (IN_CNT_W),
        .OUT_W (OUT_CNT_W)
    ) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .din     (entry),
        .pop     (pop),
        .dout    (head),
        .full    (stat.full),
        .empty   (stat.empty),
        .wptr    (stat.wptr),
        .rptr    (stat.rptr),
        .in_cnt  (stat.in_cnt),
        .out_cnt (stat.out_cnt)
    );
endmodule

// File: rtl/ipc_mbox_irq.sv
module ipc_mbox_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond,
    input  logic         en_we,
    input  logic         ack_we,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] en_q,
    output logic [N-1:0] lat_q
);
    logic [N-1:0] clr;

    assign clr = ack_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            lat_q <= '0;
        end else begin
            if (en_we) en_q <= wbits;
            lat_q <= (lat_q | cond) & ~clr;
        end
    end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              reg_rd_en,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq_send_empty,
    output logic              irq_recv_not_empty
);
    mbox_msg_t          head [NUM_DIR];
    fifo_stat_t         stat [NUM_DIR];
    logic [NUM_DIR-1:0] wr_hi, wr_lo, pop_req;
    logic [NUM_DIR-1:0] fifo_full, fifo_empty;
    logic [PTR_W-1:0]   a2i_wptr, i2a_rptr;
    logic [NUM_SRC-1:0] cond, irq_en, irq_lat;
    logic [WORD_W-1:0]  rd_val;

    always_comb begin
        for (int d = 0; d < NUM_DIR; d++) begin
            wr_hi[d]   = reg_wr_en && (reg_addr == send_hi_addr(d));
            wr_lo[d]   = reg_wr_en && (reg_addr == send_lo_addr(d));
            pop_req[d] = reg_rd_en && (reg_addr == recv_lo_addr(d));
        end
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        ipc_mbox_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .wr_hi   (wr_hi[d]),
            .wr_lo   (wr_lo[d]),
            .wdata   (reg_wdata),
            .pop_req (pop_req[d]),
            .head    (head[d]),
            .stat    (stat[d])
        );
        assign fifo_full[d]  = stat[d].full;
        assign fifo_empty[d] = stat[d].empty;
        assign cond[2*d]     = stat[d].empty;
        assign cond[2*d+1]   = !stat[d].empty;
    end

    assign a2i_wptr = stat[0].wptr;
    assign i2a_rptr = stat[1].rptr;

    ipc_mbox_irq #(.N(NUM_SRC)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .cond   (cond),
        .en_we  (reg_wr_en && (reg_addr == IRQ_EN_ADDR)),
        .ack_we (reg_wr_en && (reg_addr == IRQ_ACK_ADDR)),
        .wbits  (reg_wdata[NUM_SRC-1:0]),
        .en_q   (irq_en),
        .lat_q  (irq_lat)
    );

    assign irq_send_empty     = irq_lat[0] & irq_en[0];
    assign irq_recv_not_empty = irq_lat[3] & irq_en[3];

    always_comb begin
        rd_val = '0;
        if (reg_addr == IRQ_EN_ADDR)  rd_val[NUM_SRC-1:0] = irq_en;
        if (reg_addr == IRQ_ACK_ADDR) rd_val[NUM_SRC-1:0] = irq_lat;
        for (int d = 0; d < NUM_DIR; d++) begin
            if (reg_addr == ctl_addr(d)) begin
                rd_val[FULL_BIT]  = stat[d].full;
                rd_val[EMPTY_BIT] = stat[d].empty;
            end
            if (reg_addr == recv_hi_addr(d) && !stat[d].empty) begin
                rd_val = head[d].hi;
            end
            if (reg_addr == recv_lo_addr(d) && !stat[d].empty) begin
                rd_val = pack_recv_lo(stat[d], head[d].lo);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else begin
            reg_rdata <= reg_rd_en ? rd_val : '0;
        end
    end
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk
    import ipc_mbox_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr_en,
    input logic [WORD_W-1:0] reg_wdata,
    input logic              reg_rd_en,
    input logic [WORD_W-1:0] reg_rdata,
    input logic              irq_send_empty,
    input logic              irq_recv_not_empty,
    input logic [1:0]        fifo_full,
    input logic [1:0]        fifo_empty,
    input logic [PTR_W-1:0]  a2i_wptr,
    input logic [PTR_W-1:0]  i2a_rptr
);
    // R2: full and empty never together
    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        (fifo_full & fifo_empty) == 2'b00);

    // R4: send into a full queue leaves the write pointer alone
    a_r4_full_drops_push: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == send_lo_addr(0) && fifo_full[0]) |=> $stable(a2i_wptr));

    // R5: receive read of empty queue returns zero
    a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && reg_addr == recv_lo_addr(1) && fifo_empty[1]) |=> (reg_rdata == '0));

    // R5: receive read of empty queue keeps read pointer
    a_r5_empty_keeps_rptr: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && reg_addr == recv_lo_addr(1) && fifo_empty[1]) |=> $stable(i2a_rptr));

    // R6: write pointer moves by one step at a time
    a_r6_wptr_step: assert property (@(posedge clk) disable iff (rst)
        (a2i_wptr != $past(a2i_wptr)) |-> (a2i_wptr == $past(a2i_wptr) + PTR_W'(1)));

    // R8: acknowledging source 0 drops the output for the next cycle
    a_r8_ack_drops_irq: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == IRQ_ACK_ADDR && reg_wdata[0]) |=> !irq_send_empty);

    // R9: clearing enable bit 3 masks the receive interrupt
    a_r9_disable_masks: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == IRQ_EN_ADDR && !reg_wdata[3]) |=> !irq_recv_not_empty);

    // R10: unmapped offset reads zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_en && reg_addr == 8'h00) |=> (reg_rdata == '0));
endmodule

bind ipc_mailbox ipc_mailbox_chk u_chk (
    .clk                (clk),
    .rst                (rst),
    .reg_addr           (reg_addr),
    .reg_wr_en          (reg_wr_en),
    .reg_wdata          (reg_wdata),
    .reg_rd_en          (reg_rd_en),
    .reg_rdata          (reg_rdata),
    .irq_send_empty     (irq_send_empty),
    .irq_recv_not_empty (irq_recv_not_empty),
    .fifo_full          (fifo_full),
    .fifo_empty         (fifo_empty),
    .a2i_wptr           (a2i_wptr),
    .i2a_rptr           (i2a_rptr)
);

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic        reg_rd_en = 1'b0;
    logic [63:0] reg_rdata;
    logic        irq_send_empty;
    logic        irq_recv_not_empty;

    int checks = 0;
    int fails  = 0;

    // bench model per queue
    logic [95:0] mq [2][$];
    int wp [2];
    int rp [2];
    int pc [2];
    int oc [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    ipc_mailbox dut_i (
        .clk                (clk),
        .rst                (rst),
        .reg_addr           (reg_addr),
        .reg_wr_en          (reg_wr_en),
        .reg_wdata          (reg_wdata),
        .reg_rd_en          (reg_rd_en),
        .reg_rdata          (reg_rdata),
        .irq_send_empty     (irq_send_empty),
        .irq_recv_not_empty (irq_recv_not_empty)
    );

    function automatic logic [7:0] base(input int d);
        return (d == 0) ? 8'h50 : 8'h80;
    endfunction

    function automatic logic [63:0] exp_ctl(input int d);
        logic [63:0] r = '0;
        r[16] = (mq[d].size() == 16);
        r[17] = (mq[d].size() == 0);
        return r;
    endfunction

    function automatic logic [63:0] exp_hi(input int d);
        if (mq[d].size() == 0) return '0;
        return mq[d][0][95:32];
    endfunction

    function automatic logic [63:0] exp_lo(input int d);
        logic [63:0] r = '0;
        if (mq[d].size() == 0) return '0;
        r[31:0]  = mq[d][0][31:0];
        r[43:40] = 4'(wp[d]);
        r[47:44] = 4'(rp[d]);
        r[51:48] = 4'(pc[d]);
        r[56:52] = 5'(oc[d]);
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd_en = 1'b1;
        @(negedge clk);
        reg_rd_en = 1'b0;
        v = reg_rdata;
    endtask

    task automatic send(input int d, input logic [63:0] hi, input logic [31:0] lo);
        wr(base(d) + 8'h10, hi);
        wr(base(d) + 8'h18, {32'hDEAD_0000, lo});
        if (mq[d].size() < 16) begin
            mq[d].push_back({hi, lo});
            wp[d] = (wp[d] + 1) % 16;
            if (pc[d] < 15) pc[d]++;
        end
    endtask

    task automatic recv(input int d, input string req);
        logic [63:0] v;
        logic [63:0] e;
        e = exp_hi(d);
        rd(base(d) + 8'h20, v);
        chk({req, " R5 peek"}, v, e);
        e = exp_lo(d);
        rd(base(d) + 8'h28, v);
        chk({req, " R6 recv word"}, v, e);
        if (mq[d].size() > 0) begin
            void'(mq[d].pop_front());
            rp[d] = (rp[d] + 1) % 16;
            if (oc[d] < 31) oc[d]++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] v;
        void'($urandom(32'h5EED_1234));
        for (int d = 0; d < 2; d++) begin
            wp[d] = 0; rp[d] = 0; pc[d] = 0; oc[d] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(2);

        // reset state
        chk("R9 reset irq_send_empty", 64'(irq_send_empty), 64'd0);
        chk("R9 reset irq_recv_not_empty", 64'(irq_recv_not_empty), 64'd0);
        rd(8'h48, v); chk("R9 reset enable", v, 64'd0);
        rd(8'h4C, v); chk("R7 latched empties", v, 64'h5);
        rd(8'h50, v); chk("R2 reset ctl outbound", v, exp_ctl(0));
        rd(8'h80, v); chk("R2 reset ctl inbound", v, exp_ctl(1));

        // enable sources 0 and 3
        wr(8'h48, 64'h9);
        chk("R9 enable shows latched", 64'(irq_send_empty), 64'd1);
        chk("R9 recv not empty idle", 64'(irq_recv_not_empty), 64'd0);
        rd(8'h48, v); chk("R9 enable readback", v, 64'h9);

        // ack while still empty: one-cycle drop then back
        wr(8'h4C, 64'h1);
        chk("R8 drop after ack", 64'(irq_send_empty), 64'd0);
        idle(1);
        chk("R8 reassert next cycle", 64'(irq_send_empty), 64'd1);

        // inbound not-empty latches and holds
        send(1, 64'h1111_2222_3333_4444, 32'hAAAA_0001);
        idle(2);
        chk("R7 recv irq set", 64'(irq_recv_not_empty), 64'd1);
        recv(1, "R1 single");
        idle(2);
        chk("R7 recv irq held after drain", 64'(irq_recv_not_empty), 64'd1);
        rd(8'h4C, v); chk("R7 latched set", v, 64'hD);
        wr(8'h4C, 64'h8);
        idle(2);
        chk("R8 ack without condition stays clear", 64'(irq_recv_not_empty), 64'd0);

        // outbound empty stays latched while data present
        send(0, 64'h0BAD_CAFE_0000_0001, 32'h1234_5678);
        idle(1);
        chk("R7 send irq held while nonempty", 64'(irq_send_empty), 64'd1);
        wr(8'h4C, 64'h1);
        idle(2);
        chk("R8 ack clears while nonempty", 64'(irq_send_empty), 64'd0);
        recv(0, "R1 outbound");
        idle(2);
        chk("R7 send irq on empty", 64'(irq_send_empty), 64'd1);
        wr(8'h48, 64'h0);
        chk("R9 disable masks", 64'(irq_send_empty), 64'd0);

        // unmapped and read-only offsets
        wr(8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(8'h00, v); chk("R10 unmapped 0x00", v, 64'd0);
        rd(8'h40, v); chk("R10 unmapped 0x40", v, 64'd0);
        wr(8'h50, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(8'h78, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(8'h50, v); chk("R10 control write ignored", v, exp_ctl(0));
        rd(8'h48, v); chk("R10 enable untouched", v, 64'd0);

        // empty reads
        rd(8'hA8, v); chk("R5 empty recv word", v, 64'd0);
        rd(8'hA0, v); chk("R5 empty peek", v, 64'd0);
        rd(8'h78, v); chk("R5 empty outbound recv", v, 64'd0);

        // fill outbound to 16 plus one overflow
        for (int i = 0; i < 17; i++) begin
            send(0, {32'hC0DE_0000, 32'(i)}, 32'h5500_0000 + 32'(i));
        end
        rd(8'h50, v); chk("R3 full flag", v, 64'h1_0000);
        rd(8'h80, v); chk("R11 inbound unaffected", v, exp_ctl(1));
        rd(8'h70, v); chk("R5 peek 1", v, exp_hi(0));
        rd(8'h70, v); chk("R5 peek repeat", v, exp_hi(0));
        for (int i = 0; i < 16; i++) begin
            recv(0, "R4 drain after overflow");
        end
        rd(8'h50, v); chk("R2 empty after drain", v, 64'h2_0000);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int d;
            int op;
            d  = int'($urandom_range(0, 1));
            op = int'($urandom_range(0, 9));
            if (op < 5) begin
                send(d, {$urandom, $urandom}, $urandom);
            end else if (op < 9) begin
                recv(d, "R1 random");
            end else begin
                rd(base(d), v); chk("R2 random ctl", v, exp_ctl(d));
            end
        end
        for (int d = 0; d < 2; d++) begin
            while (mq[d].size() > 0) recv(d, "R11 final drain");
            rd(base(d), v); chk("R2 final empty", v, exp_ctl(d));
        end

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule